// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block turns five protocol status conditions into one host interrupt line. A host writes an 8-bit mask. Each mask bit sits at the same bit position as the status bit it enables. The interrupt output is high while any enabled status bit is set. Only five status positions can ever raise the interrupt. The mask register can never store a 1 at any other position.

Two of the sources are level conditions: receiver inhibited and transmitter available. The block registers them from live inputs and does not latch them. The other three are sticky flags, each set by a one-cycle pulse from the protocol engine:

- The reconfiguration flag is cleared by a clear-flags command strobe.
- The excessive-NAK flag is cleared by a power-on clear-flags command strobe.
- The new-next-ID flag is cleared by the strobe that marks a host read of the next-ID register.

When a flag's set pulse and its clear event arrive in the same cycle, the set wins. The mask returns to zero on a hardware reset and on a software reset strobe.

Top module: `irq_mask_ctrl`

## Requirements
- R1: The status byte has transmitter available at bit 0, excessive NAK at bit 1, reconfiguration at bit 2, new next ID at bit 4 and receiver inhibited at bit 7. Bits 3, 5 and 6 always read 0.
- R2: A mask write stores only bits 0, 1, 2, 4 and 7 of the write data. Bits 3, 5 and 6 of the mask read back as 0. The new value is visible the cycle after the write strobe.
- R3: `irq` equals the OR over all bits of status AND mask, at every cycle.
- R4: Status bits 7 and 0 show the values the live inputs had one clock earlier. Clearing their mask bit hides the interrupt. Setting the mask bit again brings the interrupt back only if the condition is still present.
- R5: A reconfiguration pulse sets status bit 2, which holds until a `clr_flags_cmd` strobe clears it.
- R6: An excessive-NAK pulse sets status bit 1, which holds until a `por_clr_cmd` strobe clears it.
- R7: A new-next-ID pulse sets status bit 4, which holds until a `nid_read` strobe clears it.
- R8: If a sticky bit's set pulse and its own clear strobe occur in the same cycle, the bit is 1 afterwards.
- R9: The mask is 0x00 after hardware reset and after a `sw_reset` strobe. `sw_reset` takes precedence over a mask write in the same cycle and leaves all status bits unchanged.
- R10: After hardware reset all status bits are 0. Each clear strobe affects only its own sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_reset | input | 1 | Software reset strobe, clears the mask |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Current mask value |
| status_rdata | output | 8 | Current status byte |
| clr_flags_cmd | input | 1 | Clear-flags command strobe (reconfiguration flag) |
| por_clr_cmd | input | 1 | Power-on clear-flags command strobe (excessive-NAK flag) |
| nid_read | input | 1 | Host read of the next-ID register (clears new-next-ID flag) |
| rx_inhibit_in | input | 1 | Live receiver-inhibited condition |
| tx_avail_in | input | 1 | Live transmitter-available condition |
| recon_pulse | input | 1 | Reconfiguration event pulse |
| excnak_pulse | input | 1 | Excessive-NAK event pulse |
| newid_pulse | input | 1 | New-next-ID event pulse |
| irq | output | 1 | Interrupt output |

## Verification
The bench targets four kinds of corner case.

- Same-cycle set and clear. A design where the clear wins would lose the event, and status would read 0.
- Clear strobes that belong to another source. A design with shared clears would wipe an unrelated flag.
- Writing all ones to the mask. If the undefined positions were stored, those bits would read back as 1.
- Hiding a live condition and unmasking it again, once after the condition has dropped. A design that latched live conditions would raise a stale interrupt.

A software reset is also issued in the same cycle as a mask write. A design that ordered these wrongly would keep the written mask.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned POS_TXAV   = 0;
  localparam int unsigned POS_EXCNAK = 1;
  localparam int unsigned POS_RECON  = 2;
  localparam int unsigned POS_NEWID  = 4;
  localparam int unsigned POS_RXINH  = 7;

  localparam int unsigned NUM_STICKY = 3;
  localparam int unsigned NUM_LIVE   = 2;

  typedef enum logic [1:0] {
    STK_RECON  = 2'd0,
    STK_EXCNAK = 2'd1,
    STK_NEWID  = 2'd2
  } sticky_idx_e;

  function automatic int unsigned sticky_pos(input int unsigned idx);
    case (idx)
      0:       return POS_RECON;
      1:       return POS_EXCNAK;
      default: return POS_NEWID;
    endcase
  endfunction

  function automatic int unsigned live_pos(input int unsigned idx);
    return (idx == 0) ? POS_TXAV : POS_RXINH;
  endfunction

  localparam logic [REG_W-1:0] MASKABLE =
    (REG_W'(1) << POS_TXAV)  | (REG_W'(1) << POS_EXCNAK) |
    (REG_W'(1) << POS_RECON) | (REG_W'(1) << POS_NEWID)  |
    (REG_W'(1) << POS_RXINH);
endpackage

// File: rtl/irqm_rst_sync.sv
module irqm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irqm_sticky.sv
module irqm_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      flag_en[g] = set_i[g] | clr_i[g];
      flag_d[g]  = set_i[g] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[g] <= 1'b0;
      else if (flag_en[g]) flag_q[g] <= flag_d[g];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqm_live_reg.sv
module irqm_live_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  output logic [N-1:0] cond_o
);
  logic [N-1:0] cond_q;
  logic [N-1:0] cond_d;
  logic         cond_en;

  always_comb begin
    cond_d  = cond_i;
    cond_en = (cond_i != cond_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cond_q <= '0;
    else if (cond_en) cond_q <= cond_d;
  end

  assign cond_o = cond_q;
endmodule

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg #(
  parameter int unsigned         W        = 8,
  parameter logic [W-1:0]        WRITABLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_reset,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_en = sw_reset | we;
    if (sw_reset) mask_d = '0;
    else          mask_d = wdata & WRITABLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             mask_we,
  input  logic [REG_W-1:0] mask_wdata,
  output logic [REG_W-1:0] mask_rdata,
  output logic [REG_W-1:0] status_rdata,
  input  logic             clr_flags_cmd,
  input  logic             por_clr_cmd,
  input  logic             nid_read,
  input  logic             rx_inhibit_in,
  input  logic             tx_avail_in,
  input  logic             recon_pulse,
  input  logic             excnak_pulse,
  input  logic             newid_pulse,
  output logic             irq
);
  logic                  rst_n_sync;
  logic [NUM_STICKY-1:0] stk_set;
  logic [NUM_STICKY-1:0] stk_clr;
  logic [NUM_STICKY-1:0] stk_flag;
  logic [NUM_LIVE-1:0]   live_in;
  logic [NUM_LIVE-1:0]   live_q;
  logic [REG_W-1:0]      status_vec;
  logic [REG_W-1:0]      mask_vec;

  irqm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    stk_set = '0;
    stk_clr = '0;
    stk_set[STK_RECON]  = recon_pulse;
    stk_set[STK_EXCNAK] = excnak_pulse;
    stk_set[STK_NEWID]  = newid_pulse;
    stk_clr[STK_RECON]  = clr_flags_cmd;
    stk_clr[STK_EXCNAK] = por_clr_cmd;
    stk_clr[STK_NEWID]  = nid_read;
    live_in = {rx_inhibit_in, tx_avail_in};
  end

  irqm_sticky #(.N(NUM_STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (stk_set),
    .clr_i  (stk_clr),
    .flag_o (stk_flag)
  );

  irqm_live_reg #(.N(NUM_LIVE)) u_live (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .cond_i (live_in),
    .cond_o (live_q)
  );

  irqm_mask_reg #(.W(REG_W), .WRITABLE(MASKABLE)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .sw_reset (sw_reset),
    .we       (mask_we),
    .wdata    (mask_wdata),
    .mask_o   (mask_vec)
  );

  always_comb begin
    status_vec = '0;
    for (int i = 0; i < NUM_STICKY; i++) status_vec[sticky_pos(i)] = stk_flag[i];
    for (int j = 0; j < NUM_LIVE; j++)   status_vec[live_pos(j)]   = live_q[j];
  end

  assign status_rdata = status_vec;
  assign mask_rdata   = mask_vec;
  assign irq          = |(status_vec & mask_vec);
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
  import irqm_pkg::*;
(
  input logic             clk,
  input logic             rst_n_int,
  input logic             sw_reset,
  input logic             mask_we,
  input logic [REG_W-1:0] mask_wdata,
  input logic [REG_W-1:0] mask_rdata,
  input logic [REG_W-1:0] status_rdata,
  input logic             clr_flags_cmd,
  input logic             por_clr_cmd,
  input logic             nid_read,
  input logic             rx_inhibit_in,
  input logic             recon_pulse,
  input logic             excnak_pulse,
  input logic             newid_pulse,
  input logic             irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (status_rdata & ~MASKABLE) == '0); // R1
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mask_we && !sw_reset) |=> mask_rdata == ($past(mask_wdata) & MASKABLE)); // R2
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq == |(status_rdata & mask_rdata)); // R3
  AST_RX_LIVE: assert property (@(posedge clk) disable iff (!rst_n_int)
    rst_n_int |=> status_rdata[POS_RXINH] == $past(rx_inhibit_in)); // R4
  AST_RECON_CLR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (clr_flags_cmd && !recon_pulse) |=> !status_rdata[POS_RECON]); // R5
  AST_EXCNAK_CLR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (por_clr_cmd && !excnak_pulse) |=> !status_rdata[POS_EXCNAK]); // R6
  AST_NEWID_CLR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (nid_read && !newid_pulse) |=> !status_rdata[POS_NEWID]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n_int)
    recon_pulse |=> status_rdata[POS_RECON]); // R8
  AST_SWRST_MASK: assert property (@(posedge clk) disable iff (!rst_n_int)
    sw_reset |=> mask_rdata == '0); // R9
  AST_EXCNAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!excnak_pulse && !por_clr_cmd) |=> $stable(status_rdata[POS_EXCNAK])); // R10
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n_int     (rst_n_sync),
  .sw_reset      (sw_reset),
  .mask_we       (mask_we),
  .mask_wdata    (mask_wdata),
  .mask_rdata    (mask_rdata),
  .status_rdata  (status_rdata),
  .clr_flags_cmd (clr_flags_cmd),
  .por_clr_cmd   (por_clr_cmd),
  .nid_read      (nid_read),
  .rx_inhibit_in (rx_inhibit_in),
  .recon_pulse   (recon_pulse),
  .excnak_pulse  (excnak_pulse),
  .newid_pulse   (newid_pulse),
  .irq           (irq)
);

// File: tb/sim_irq_mask_ctrl.sv
module sim_irq_mask_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_reset = 0, mask_we = 0;
  logic [7:0] mask_wdata = 0;
  logic [7:0] mask_rdata, status_rdata;
  logic       clr_flags_cmd = 0, por_clr_cmd = 0, nid_read = 0;
  logic       rx_inhibit_in = 0, tx_avail_in = 0;
  logic       recon_pulse = 0, excnak_pulse = 0, newid_pulse = 0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_mask = 0;
  logic       e_tx = 0, e_exc = 0, e_rec = 0, e_nid = 0, e_rx = 0;

  always #10 clk = ~clk;

  irq_mask_ctrl u0 (.*);

  function automatic logic [7:0] exp_status();
    return {e_rx, 2'b00, e_nid, 1'b0, e_rec, e_exc, e_tx};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "status", status_rdata, exp_status());
    chk(req, "mask", mask_rdata, exp_mask);
    chk("R3", "irq", {7'd0, irq}, {7'd0, |(exp_status() & exp_mask)});
  endtask

  task automatic step(input string req);
    @(posedge clk);
    if (sw_reset)     exp_mask = 8'h00;
    else if (mask_we) exp_mask = mask_wdata & 8'h97;
    e_rx  = rx_inhibit_in;
    e_tx  = tx_avail_in;
    e_rec = recon_pulse  | (e_rec & ~clr_flags_cmd);
    e_exc = excnak_pulse | (e_exc & ~por_clr_cmd);
    e_nid = newid_pulse  | (e_nid & ~nid_read);
    @(negedge clk);
    {sw_reset, mask_we, clr_flags_cmd, por_clr_cmd, nid_read} = '0;
    {recon_pulse, excnak_pulse, newid_pulse} = '0;
    check_all(req);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R10 R9 R1 reset");

    mask_we = 1; mask_wdata = 8'hFF; step("R2 all-ones write");
    chk("R2", "reserved mask bits", mask_rdata & 8'h68, 8'h00);

    recon_pulse = 1; step("R5 set");
    por_clr_cmd = 1; nid_read = 1; step("R10 foreign clears");
    clr_flags_cmd = 1; step("R5 clear");

    excnak_pulse = 1; newid_pulse = 1; step("R6 R7 set");
    clr_flags_cmd = 1; step("R10 clr_flags leaves others");
    por_clr_cmd = 1; step("R6 clear");
    nid_read = 1; step("R7 clear");

    recon_pulse = 1; clr_flags_cmd = 1; step("R8 recon");
    excnak_pulse = 1; por_clr_cmd = 1; step("R8 excnak");
    newid_pulse = 1; nid_read = 1; step("R8 newid");

    rx_inhibit_in = 1; step("R4 rx live");
    mask_we = 1; mask_wdata = 8'h17; step("R4 hide rx");
    mask_we = 1; mask_wdata = 8'h97; step("R4 reveal rx");
    mask_we = 1; mask_wdata = 8'h00; step("R4 hide again");
    rx_inhibit_in = 0; step("R4 condition drops");
    mask_we = 1; mask_wdata = 8'h80; step("R4 no stale irq");
    chk("R4", "irq after drop", {7'd0, irq}, 8'h00);
    tx_avail_in = 1; mask_we = 1; mask_wdata = 8'h01; step("R4 tx");

    sw_reset = 1; mask_we = 1; mask_wdata = 8'hFF; step("R9 sw_reset beats write");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      rx_inhibit_in = r[0];
      tx_avail_in   = r[1];
      recon_pulse   = (r[4:2] == 0);
      excnak_pulse  = (r[7:5] == 0);
      newid_pulse   = (r[10:8] == 0);
      clr_flags_cmd = (r[13:11] == 0);
      por_clr_cmd   = (r[16:14] == 0);
      nid_read      = (r[19:17] == 0);
      mask_we       = (r[21:20] == 0);
      mask_wdata    = r[29:22];
      sw_reset      = (r[31:30] == 0) && r[0] && r[1];
      step("R1 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule